// File: doc/BRIEF.md
# Selectable Link Error Event Counter

This block holds one 32-bit event counter and a handful of byte-wide configuration registers behind a small byte-addressed port. Two single-cycle inputs signal link-level CRC failures: one for the link CRC check and one for the end-to-end CRC check. Software writes a group code and an event code to pick which of the two failures is counted. It writes a control byte to clear the count and to arm counting. It then reads the count back as four bytes. A separate configuration byte holds a check-enable bit. When that bit is low, end-to-end CRC failures are not counted.

The register window moves with the link width parameter, so the same block can sit beside x16, x8 or x4 link logic. The counter stops at its largest value instead of wrapping. The count width is a parameter and defaults to 32 bits. A narrower count reads back zero-extended.

Top module: `lerr_event_ctr`

## Requirements
- R1: After reset, every register and the counter are zero, so every readable byte returns 0x00.
- R2: The control byte sits at base 0x36C (x16), 0x32C (x8) or 0x2D4 (x4). Counting is armed only while the last value written to control bits [4:2] is 3'b111. The control byte reads back as bits [4:2] holding those stored bits and every other bit zero.
- R3: A write to the control byte with bits [1:0] equal to 2'b11 sets the counter to zero on that clock edge. When such a write and a selected event fall in the same cycle, the counter still ends at zero.
- R4: With group byte (base+3) at 0x02 and event byte (base+2) at 0x01, each cycle in which the link-CRC error input is high adds one to the counter while counting is armed.
- R5: With group 0x03 and event 0x02, each cycle in which the end-to-end CRC error input is high adds one, but only while bit 0 of the byte at 0x119 is set.
- R6: Any other group/event pair selects no source, and the counter holds whatever errors arrive.
- R7: Bytes base+4 through base+7 return counter bits [7:0], [15:8], [23:16] and [31:24], in that order. Writes to them do not change the count.
- R8: The counter stops at its all-ones value and does not wrap.
- R9: Byte base+1 always reads 0x00 and ignores writes. Any offset outside the mapped bytes reads 0x00.
- R10: Read data appears on the cycle after the read strobe and holds its value until the next read.
- R11: The byte at 0x119 is read/write, and its bit 0 is the end-to-end CRC check enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 32 | Byte address |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write byte |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read byte, registered |
| lcrc_err | input | 1 | Link CRC error pulse |
| ecrc_err | input | 1 | End-to-end CRC error pulse |

## Verification
The counter can be cleared and incremented in the same cycle. The bench provokes this by holding the link-CRC error input high on the very cycle that carries the clearing control write, with the link-CRC source already selected and armed. It judges the result by reading the low count byte afterwards and expecting 0x00 rather than 0x01. A second instance with an 8-bit count is driven past its limit and must read 0xFF. The main instance, fed the same 300 events, must read 0x012C.

// File: rtl/lerr_pkg.sv
package lerr_pkg;

    localparam logic [31:0] AER_CTRL_ADDR = 32'h0000_0119;

    localparam logic [7:0] GRP_LINK = 8'h02;
    localparam logic [7:0] EVT_LINK = 8'h01;
    localparam logic [7:0] GRP_E2E  = 8'h03;
    localparam logic [7:0] EVT_E2E  = 8'h02;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LINK = 2'd1,
        SRC_E2E  = 2'd2
    } src_e;

    typedef enum logic [3:0] {
        RG_NONE, RG_AER, RG_CTRL, RG_RSVD, RG_EVT, RG_GRP,
        RG_CNT0, RG_CNT1, RG_CNT2, RG_CNT3
    } reg_e;

    typedef struct packed {
        logic clr;
        logic en;
        src_e src;
    } cnt_ctl_t;

    function automatic logic [31:0] base_for_lanes(input int lanes);
        case (lanes)
            16:      return 32'h0000_036C;
            8:       return 32'h0000_032C;
            default: return 32'h0000_02D4;
        endcase
    endfunction

    function automatic reg_e decode_addr(input logic [31:0] a, input logic [31:0] base);
        logic [31:0] off;
        off = a - base;
        if (a == AER_CTRL_ADDR) return RG_AER;
        if (a < base)           return RG_NONE;
        case (off)
            32'd0:   return RG_CTRL;
            32'd1:   return RG_RSVD;
            32'd2:   return RG_EVT;
            32'd3:   return RG_GRP;
            32'd4:   return RG_CNT0;
            32'd5:   return RG_CNT1;
            32'd6:   return RG_CNT2;
            32'd7:   return RG_CNT3;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic src_e pick_source(input logic [7:0] grp, input logic [7:0] evt);
        if (grp == GRP_LINK && evt == EVT_LINK) return SRC_LINK;
        if (grp == GRP_E2E  && evt == EVT_E2E)  return SRC_E2E;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/lerr_regfile.sv
module lerr_regfile
    import lerr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  reg_e       sel,
    input  logic [7:0] wdata,
    output logic [7:0] aer_q,
    output logic [7:0] ctrl_rb,
    output logic [7:0] evt_q,
    output logic [7:0] grp_q,
    output cnt_ctl_t   ctl
);
    logic [2:0] arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            aer_q <= '0;
            arm_q <= '0;
            evt_q <= '0;
            grp_q <= '0;
        end else if (wr) begin
            case (sel)
                RG_AER:  aer_q <= wdata;
                RG_CTRL: arm_q <= wdata[4:2];
                RG_EVT:  evt_q <= wdata;
                RG_GRP:  grp_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_rb = {3'b000, arm_q, 2'b00};
        ctl.clr = wr && (sel == RG_CTRL) && (wdata[1:0] == 2'b11);
        ctl.en  = (arm_q == 3'b111);
        ctl.src = pick_source(grp_q, evt_q);
    end

endmodule

// File: rtl/lerr_counter.sv
module lerr_counter
    import lerr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic             link_err,
    input  logic             e2e_err,
    input  logic             e2e_chk_en,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hit;

    always_comb begin
        case (ctl.src)
            SRC_LINK: hit = link_err;
            SRC_E2E:  hit = e2e_err && e2e_chk_en;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt_q <= '0;
        end else if (ctl.en && hit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lerr_rdmux.sv
module lerr_rdmux
    import lerr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  reg_e             sel,
    input  logic [7:0]       aer_q,
    input  logic [7:0]       ctrl_rb,
    input  logic [7:0]       evt_q,
    input  logic [7:0]       grp_q,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [7:0]       rdata
);
    localparam int RD_W = 32;

    logic [RD_W-1:0] cnt_ext;
    logic [3:0][7:0] cnt_b;
    logic [7:0]      rd_nxt;

    generate
        if (CNT_W < RD_W) begin : g_pad
            assign cnt_ext = {{(RD_W-CNT_W){1'b0}}, cnt_q};
        end else begin : g_full
            assign cnt_ext = cnt_q[RD_W-1:0];
        end
    endgenerate

    assign cnt_b = cnt_ext;

    always_comb begin
        case (sel)
            RG_AER:  rd_nxt = aer_q;
            RG_CTRL: rd_nxt = ctrl_rb;
            RG_EVT:  rd_nxt = evt_q;
            RG_GRP:  rd_nxt = grp_q;
            RG_CNT0: rd_nxt = cnt_b[0];
            RG_CNT1: rd_nxt = cnt_b[1];
            RG_CNT2: rd_nxt = cnt_b[2];
            RG_CNT3: rd_nxt = cnt_b[3];
            default: rd_nxt = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= 8'h00;
        else if (rd) rdata <= rd_nxt;
    end

endmodule

// File: rtl/lerr_event_ctr.sv
module lerr_event_ctr
    import lerr_pkg::*;
#(
    parameter int LINK_LANES = 16,
    parameter int CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_addr,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_wdata,
    input  logic        cfg_rd,
    output logic [7:0]  cfg_rdata,
    input  logic        lcrc_err,
    input  logic        ecrc_err
);
    localparam logic [31:0] WIN_BASE = base_for_lanes(LINK_LANES);

    reg_e             sel;
    cnt_ctl_t         ctl;
    logic [7:0]       aer_q;
    logic [7:0]       ctrl_rb;
    logic [7:0]       evt_q;
    logic [7:0]       grp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ecrc_chk_en;

    assign sel         = decode_addr(cfg_addr, WIN_BASE);
    assign ecrc_chk_en = aer_q[0];

    lerr_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .sel     (sel),
        .wdata   (cfg_wdata),
        .aer_q   (aer_q),
        .ctrl_rb (ctrl_rb),
        .evt_q   (evt_q),
        .grp_q   (grp_q),
        .ctl     (ctl)
    );

    lerr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .link_err   (lcrc_err),
        .e2e_err    (ecrc_err),
        .e2e_chk_en (ecrc_chk_en),
        .cnt_q      (cnt_q)
    );

    lerr_rdmux #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (cfg_rd),
        .sel     (sel),
        .aer_q   (aer_q),
        .ctrl_rb (ctrl_rb),
        .evt_q   (evt_q),
        .grp_q   (grp_q),
        .cnt_q   (cnt_q),
        .rdata   (cfg_rdata)
    );

endmodule

// File: rtl/lerr_chk.sv
module lerr_chk
    import lerr_pkg::*;
#(
    parameter int LINK_LANES = 16,
    parameter int CNT_W      = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [31:0]      cfg_addr,
    input logic             cfg_wr,
    input logic [1:0]       clr_bits,
    input logic             cfg_rd,
    input logic [7:0]       cfg_rdata,
    input logic             lcrc_err,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ecrc_chk_en
);
    localparam logic [31:0]      CHK_BASE = base_for_lanes(LINK_LANES);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic clr_seen;
    assign clr_seen = cfg_wr && (cfg_addr == CHK_BASE) && (clr_bits == 2'b11);

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_seen |=> (cnt_q == '0));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == ALL_ONES) && !clr_seen |=> (cnt_q == ALL_ONES));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_seen |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R5
    e2e_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_seen && !lcrc_err && !ecrc_chk_en |=> $stable(cnt_q));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd && (cfg_addr == CHK_BASE + 32'd1) |=> (cfg_rdata == 8'h00));

endmodule

bind lerr_event_ctr lerr_chk #(.LINK_LANES(LINK_LANES), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_addr    (cfg_addr),
    .cfg_wr      (cfg_wr),
    .clr_bits    (cfg_wdata[1:0]),
    .cfg_rd      (cfg_rd),
    .cfg_rdata   (cfg_rdata),
    .lcrc_err    (lcrc_err),
    .cnt_q       (cnt_q),
    .ecrc_chk_en (ecrc_chk_en)
);

// File: tb/sim_lerr_event_ctr.sv
module sim_lerr_event_ctr;

    localparam logic [31:0] B   = 32'h0000_036C;
    localparam logic [31:0] AER = 32'h0000_0119;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  sat_rdata;
    logic        lcrc_err = 1'b0;
    logic        ecrc_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lerr_event_ctr #(.LINK_LANES(16), .CNT_W(32)) u0 (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .lcrc_err(lcrc_err), .ecrc_err(ecrc_err)
    );

    lerr_event_ctr #(.LINK_LANES(16), .CNT_W(8)) u_sat (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(sat_rdata),
        .lcrc_err(lcrc_err), .ecrc_err(ecrc_err)
    );

    // scoreboard queues
    logic [7:0] q_exp0[$];
    bit         q_chk1[$];
    logic [7:0] q_exp1[$];
    string      q_tag[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= cfg_rd;

    always @(negedge clk) begin
        if (rd_seen && q_tag.size() > 0) begin
            logic [7:0] e0;
            logic [7:0] e1;
            bit         c1;
            string      t;
            e0 = q_exp0.pop_front();
            c1 = q_chk1.pop_front();
            e1 = q_exp1.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (cfg_rdata !== e0) begin
                errors++;
                $display("FAIL %s: got %02h expected %02h", t, cfg_rdata, e0);
            end
            if (c1) begin
                checks++;
                if (sat_rdata !== e1) begin
                    errors++;
                    $display("FAIL %s (narrow): got %02h expected %02h", t, sat_rdata, e1);
                end
            end
        end
    end

    task automatic rd_exp(input logic [31:0] a, input logic [7:0] e0, input string tag,
                          input bit c1 = 1'b0, input logic [7:0] e1 = 8'h00);
        q_exp0.push_back(e0);
        q_chk1.push_back(c1);
        q_exp1.push_back(e1);
        q_tag.push_back(tag);
        @(negedge clk);
        cfg_addr = a;
        cfg_rd   = 1'b1;
        @(negedge clk);
        cfg_rd   = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d, input bit with_lcrc = 1'b0);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        lcrc_err  = with_lcrc;
        @(negedge clk);
        cfg_wr    = 1'b0;
        lcrc_err  = 1'b0;
    endtask

    task automatic pulse(input bit l, input bit e, input int n);
        @(negedge clk);
        lcrc_err = l;
        ecrc_err = e;
        repeat (n) @(negedge clk);
        lcrc_err = 1'b0;
        ecrc_err = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd_exp(B,       8'h00, "R1 ctrl");
        rd_exp(B + 2,   8'h00, "R1 event");
        rd_exp(B + 3,   8'h00, "R1 group");
        rd_exp(B + 4,   8'h00, "R1 count", 1'b1, 8'h00);
        rd_exp(AER,     8'h00, "R1 aer");

        // R9: reserved and unmapped bytes
        wr(B + 1, 8'hFF);
        rd_exp(B + 1,   8'h00, "R9 reserved");
        rd_exp(32'h500, 8'h00, "R9 unmapped");

        // R2, R4: arm link-CRC counting
        wr(B + 3, 8'h02);
        wr(B + 2, 8'h01);
        wr(B,     8'h1C);
        rd_exp(B,       8'h1C, "R2 ctrl readback");
        pulse(1'b1, 1'b0, 5);
        rd_exp(B + 4,   8'h05, "R4 link count");

        // R7: counter bytes ignore writes
        wr(B + 4, 8'hAA);
        rd_exp(B + 4,   8'h05, "R7 write ignored");

        // R3: clear together with an event in the same cycle
        wr(B, 8'h1F, 1'b1);
        rd_exp(B + 4,   8'h00, "R3 clear wins");
        rd_exp(B,       8'h1C, "R3 ctrl after clear");

        // R5: end-to-end source gated by check enable
        wr(B + 3, 8'h03);
        wr(B + 2, 8'h02);
        pulse(1'b0, 1'b1, 4);
        rd_exp(B + 4,   8'h00, "R5 gated off");
        wr(AER, 8'h01);
        rd_exp(AER,     8'h01, "R11 aer readback");
        pulse(1'b0, 1'b1, 3);
        pulse(1'b1, 1'b0, 2);
        rd_exp(B + 4,   8'h03, "R5 e2e count");

        // R6: unlisted pair selects nothing
        wr(B + 3, 8'h02);
        pulse(1'b1, 1'b1, 4);
        rd_exp(B + 4,   8'h03, "R6 no source");

        // R2: partial enable pattern does not arm
        wr(B + 2, 8'h01);
        wr(B, 8'h0C);
        pulse(1'b1, 1'b0, 4);
        rd_exp(B + 4,   8'h03, "R2 not armed");
        rd_exp(B,       8'h0C, "R2 partial readback");

        // R8, R7: long run, saturation on narrow instance, byte order
        wr(B, 8'h1F);
        pulse(1'b1, 1'b0, 300);
        rd_exp(B + 4,   8'h2C, "R7 byte0", 1'b1, 8'hFF);
        rd_exp(B + 5,   8'h01, "R7 byte1", 1'b1, 8'h00);
        rd_exp(B + 6,   8'h00, "R7 byte2");
        rd_exp(B + 7,   8'h00, "R8 byte3", 1'b1, 8'h00);
        rd_exp(B + 4,   8'h2C, "R8 narrow saturated", 1'b1, 8'hFF);

        // R10: read data holds with no read strobe
        cfg_addr = B + 1;
        repeat (4) @(negedge clk);
        checks++;
        if (cfg_rdata !== 8'h2C) begin
            errors++;
            $display("FAIL R10 hold: got %02h expected %02h", cfg_rdata, 8'h2C);
        end

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule